// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that holds a small bank of 8-bit configuration registers for a host controller. A fast system clock oversamples the serial clock and data lines through two-flop synchronisers. Start and stop conditions are recognised from those sampled levels. A transfer is steered by the device address, then by a command code. The command code either names one register for a single-byte access or opens a block access that begins at offset 0 and carries a byte count.

The slave pulls the data line low only through an open-drain enable. Selected register bits drive dedicated control pins: two output enables, a spread-modulation enable and a spread-mode select. The bank holds read-only identification fields. It also holds a programmable count register that sets how long a block read runs.

Top module: `smbcfg_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), which is 7-bit address 0x69 in bits 7:1 with the direction in bit 0. Any other address byte is not acknowledged. Every later byte up to the next start or stop is ignored and not acknowledged.
- R2: A command code with bit 7 = 1 selects single-byte access at offset bits 6:0. The slave writes one data byte there and acknowledges it. A second data byte in the same transfer is not acknowledged and not written.
- R3: A command code with bit 7 = 0 selects block access from offset 0. The next byte is a count N. The first N data bytes are acknowledged and stored at offsets 0, 1, 2 and so on. Data byte N+1 is not acknowledged and not written.
- R4: A byte read returns the register at the selected offset, most significant bit first.
- R5: A block read first returns the value of the count register at offset 12. It then returns that many registers, starting at offset 0. Further bytes the master requests read as 0xFF.
- R6: Reset loads these defaults: offset 4 = 0x62, offset 12 = 0x0F, offset 7 = identification byte, offset 8 = 0xA0. All other offsets load 0x00.
- R7: Offset 7 reads 0x25 (revision 2 in bits 7:4, vendor 5 in bits 3:0) and ignores writes. Bits 7:4 of offset 8 read device ID 0xA and ignore writes. Bits 3:0 of offset 8 are writable.
- R8: The control pins follow register bits: `out1_en` = offset 4 bit 6, `out2_en` = offset 4 bit 5, `spread_en` = offset 4 bit 1, `center_spread` = offset 1 bit 6 (0 down spread, 1 center spread).
- R9: A start or stop at any bit position abandons the current transfer. A partial byte is discarded without any register write, and a start begins a fresh address phase.
- R10: `sda_oe` rises only while the synchronised serial clock is low. It is 0 when the bus is idle or ignored, and it is released after each acknowledge clock.
- R11: During a read, a master NACK ends transmission and the slave releases the line. A master ACK makes the slave send another byte.
- R12: Offsets at or beyond the bank size (13) read as 0x00. Writes to them are acknowledged and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | Open-drain pull-down enable for the data line |
| out1_en | output | 1 | Output 1 enable (offset 4 bit 6) |
| out2_en | output | 1 | Output 2 enable (offset 4 bit 5) |
| spread_en | output | 1 | Spread modulation enable (offset 4 bit 1) |
| center_spread | output | 1 | Spread mode: 0 down, 1 center (offset 1 bit 6) |

## Verification
The bench targets several edge cases, each with a distinct failure it would expose:
- A count-limited block write. A design that ignored the count would acknowledge and store a fourth byte.
- A block read that runs past the count register. A design that mishandled it would stop early, skip the count byte, or keep sending register contents instead of 0xFF.
- Writes to the read-only identification nibbles and to offsets beyond the bank. A wrong design would corrupt the IDs or alias a high offset back onto a real register.
- Stop and repeated start inside a byte. A design that latched a partial byte would write garbage or leave the line pulled low.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    localparam int OFS_W           = 7;
    localparam int OE_IDX          = 4;
    localparam int SPREAD_MODE_IDX = 1;
    localparam int ID_IDX          = 7;
    localparam int DEVID_IDX       = 8;
    localparam int BC_IDX          = 12;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_COUNT,
        PH_WDATA,
        PH_RDATA,
        PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {
        ST_BITS,
        ST_ACK_SETUP,
        ST_ACK_HOLD
    } stage_e;

    typedef struct packed {
        logic out1_en;
        logic out2_en;
        logic spread_en;
        logic center_spread;
    } ctl_t;

    function automatic logic [7:0] reg_default(input int idx, input logic [7:0] id_byte,
                                               input logic [3:0] dev_nib);
        case (idx)
            OE_IDX:    return 8'h62;
            ID_IDX:    return id_byte;
            DEVID_IDX: return {dev_nib, 4'h0};
            BC_IDX:    return 8'h0F;
            default:   return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            ID_IDX:    return 8'h00;
            DEVID_IDX: return 8'h0F;
            default:   return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smbcfg_line_sync.sv
module smbcfg_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [1:0] raw;
    logic [1:0] lvl;
    logic [1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar l = 0; l < 2; l++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe    <= '1;
                prev[l] <= 1'b1;
            end else begin
                pipe    <= {pipe[SYNC_STAGES-2:0], raw[l]};
                prev[l] <= pipe[SYNC_STAGES-1];
            end
        end
        assign lvl[l] = pipe[SYNC_STAGES-1];
    end

    assign scl_lvl  = lvl[0];
    assign sda_lvl  = lvl[1];
    assign scl_rise = lvl[0] & ~prev[0];
    assign scl_fall = ~lvl[0] & prev[0];
    assign start_p  = lvl[0] & prev[0] & prev[1] & ~lvl[1];
    assign stop_p   = lvl[0] & prev[0] & ~prev[1] & lvl[1];
endmodule

// File: rtl/smbcfg_regbank.sv
module smbcfg_regbank
    import smbcfg_pkg::*;
#(
    parameter int         NREGS   = 13,
    parameter logic [7:0] ID_BYTE = 8'h25,
    parameter logic [3:0] DEV_NIB = 4'hA
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [OFS_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [OFS_W-1:0] raddr,
    output logic [7:0]       rdata,
    output logic [7:0]       byte_count,
    output ctl_t             ctl
);
    logic [7:0] regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [7:0] DEF = reg_default(g, ID_BYTE, DEV_NIB);
        localparam logic [7:0] WM  = reg_wmask(g);
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= DEF;
            else if (we && waddr == OFS_W'(g))
                q <= (q & ~WM) | (wdata & WM);
        end
        assign regs[g] = q;
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NREGS; i++)
            if (raddr == OFS_W'(i)) rdata = regs[i];
    end

    assign byte_count        = regs[BC_IDX];
    assign ctl.out1_en       = regs[OE_IDX][6];
    assign ctl.out2_en       = regs[OE_IDX][5];
    assign ctl.spread_en     = regs[OE_IDX][1];
    assign ctl.center_spread = regs[SPREAD_MODE_IDX][6];

    // R2: a write to the count register lands in the next cycle
    assert_count_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == OFS_W'(BC_IDX)) |=> byte_count == $past(wdata));
endmodule

// File: rtl/smbcfg_slave.sv
module smbcfg_slave
    import smbcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NREGS    = 13,
    parameter logic [3:0] REV_CODE = 4'h2,
    parameter logic [3:0] VENDOR   = 4'h5,
    parameter logic [3:0] DEVICE   = 4'hA
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    output logic out1_en,
    output logic out2_en,
    output logic spread_en,
    output logic center_spread
);
    localparam logic [7:0] ID_BYTE = {REV_CODE, VENDOR};

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;

    smbcfg_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_p(ev_start), .stop_p(ev_stop)
    );

    phase_e           phase;
    stage_e           stage;
    logic [7:0]       rx_sh, tx_sh, rrem, wrem;
    logic [2:0]       bcnt;
    logic [OFS_W-1:0] ptr;
    logic             ack_drv, slot_master, single_mode, count_pend;

    logic [7:0] rx_byte, rdata, byte_count, next_tx;
    logic       byte_last, active, we;
    ctl_t       ctl;

    assign rx_byte   = {rx_sh[6:0], sda_lvl};
    assign byte_last = (bcnt == 3'd7);
    assign active    = (phase != PH_IDLE) && (phase != PH_IGNORE);
    assign we        = active && !ev_start && !ev_stop && scl_rise && stage == ST_BITS
                       && byte_last && phase == PH_WDATA && wrem != 8'd0;

    smbcfg_regbank #(.NREGS(NREGS), .ID_BYTE(ID_BYTE), .DEV_NIB(DEVICE)) u_bank (
        .clk(clk), .rst(rst), .we(we), .waddr(ptr), .wdata(rx_byte),
        .raddr(ptr), .rdata(rdata), .byte_count(byte_count), .ctl(ctl)
    );

    always_comb begin
        if (count_pend)         next_tx = byte_count;
        else if (rrem != 8'd0)  next_tx = rdata;
        else                    next_tx = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;      stage <= ST_BITS;
            rx_sh <= 8'h00;        tx_sh <= 8'hFF;
            rrem <= 8'd0;          wrem <= 8'd0;
            bcnt <= 3'd0;          ptr <= '0;
            ack_drv <= 1'b0;       slot_master <= 1'b0;
            single_mode <= 1'b1;   count_pend <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev_stop) begin
            phase <= PH_IDLE;  stage <= ST_BITS;  sda_oe <= 1'b0;
        end else if (ev_start) begin
            phase <= PH_ADDR;  stage <= ST_BITS;  bcnt <= 3'd0;  sda_oe <= 1'b0;
        end else if (active && scl_rise) begin
            case (stage)
                ST_BITS: begin
                    rx_sh <= rx_byte;
                    tx_sh <= {tx_sh[6:0], 1'b1};
                    bcnt  <= bcnt + 3'd1;
                    if (byte_last) begin
                        stage       <= ST_ACK_SETUP;
                        slot_master <= (phase == PH_RDATA);
                        ack_drv     <= 1'b1;
                        case (phase)
                            PH_ADDR: begin
                                if (rx_byte[7:1] != DEV_ADDR) begin
                                    ack_drv <= 1'b0;
                                    phase   <= PH_IGNORE;
                                end else if (rx_byte[0]) begin
                                    phase      <= PH_RDATA;
                                    count_pend <= !single_mode;
                                    rrem       <= single_mode ? 8'd1 : 8'd0;
                                end else begin
                                    phase <= PH_CMD;
                                end
                            end
                            PH_CMD: begin
                                single_mode <= rx_byte[7];
                                ptr         <= rx_byte[7] ? rx_byte[6:0] : '0;
                                wrem        <= 8'd1;
                                phase       <= rx_byte[7] ? PH_WDATA : PH_COUNT;
                            end
                            PH_COUNT: begin
                                wrem  <= rx_byte;
                                phase <= PH_WDATA;
                            end
                            PH_WDATA: begin
                                if (wrem != 8'd0) begin
                                    ptr  <= ptr + 1'b1;
                                    wrem <= wrem - 8'd1;
                                end else begin
                                    ack_drv <= 1'b0;
                                    phase   <= PH_IGNORE;
                                end
                            end
                            default: ack_drv <= 1'b0;
                        endcase
                    end
                end
                ST_ACK_HOLD: begin
                    if (slot_master && sda_lvl) phase <= PH_IGNORE;
                end
                default: ;
            endcase
        end else if (active && scl_fall) begin
            case (stage)
                ST_BITS: begin
                    if (phase == PH_RDATA && bcnt != 3'd0) sda_oe <= ~tx_sh[7];
                end
                ST_ACK_SETUP: begin
                    sda_oe <= ack_drv;
                    stage  <= ST_ACK_HOLD;
                end
                default: begin
                    stage <= ST_BITS;
                    bcnt  <= 3'd0;
                    if (phase == PH_RDATA) begin
                        tx_sh  <= next_tx;
                        sda_oe <= ~next_tx[7];
                        if (count_pend) begin
                            count_pend <= 1'b0;
                            rrem       <= byte_count;
                        end else if (rrem != 8'd0) begin
                            rrem <= rrem - 8'd1;
                            ptr  <= ptr + 1'b1;
                        end
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
            endcase
        end
    end

    assign out1_en       = ctl.out1_en;
    assign out2_en       = ctl.out2_en;
    assign spread_en     = ctl.spread_en;
    assign center_spread = ctl.center_spread;

    // R10: the pull-down is applied only while the serial clock is low
    assert_pull_on_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_lvl);
    // R10: line released whenever the bus is idle
    assert_idle_release_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> !sda_oe);
    // R1: an ignored transfer never starts pulling the line
    assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> phase != PH_IGNORE);
    // R9: stop returns the slave to idle
    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> phase == PH_IDLE);
    // R9: start opens a fresh address phase with the line released
    assert_start_addr_R9: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (phase == PH_ADDR && !sda_oe));
endmodule

// File: tb/tb_smbcfg_slave.sv
module tb_smbcfg_slave;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, out1_en, out2_en, spread_en, center_spread;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smbcfg_slave dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
        .out1_en(out1_en), .out2_en(out2_en), .spread_en(spread_en),
        .center_spread(center_spread)
    );

    typedef struct {
        int         req;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] obs_q[$];
    int checks = 0;
    int failures = 0;
    int bad_pull = 0;
    bit done = 1'b0;

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string what, input int req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // scoreboard monitor: compares observed bus results against expectations
    initial begin
        forever begin
            @(negedge clk);
            if (obs_q.size() != 0 && exp_q.size() != 0) begin
                item_t e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                check("bus item", e.req, o, e.val);
            end
        end
    end

    // independent line monitor for R10
    logic oe_d = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe && !oe_d && scl) bad_pull++;
        oe_d <= sda_oe;
    end

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(Q); scl = 1'b1; wq(2 * Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); b = sda_line; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic wr(input logic [7:0] v, input logic exp_ack, input int req);
        logic s;
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        bit_in(s);
        exp_q.push_back('{req, {7'd0, exp_ack}});
        obs_q.push_back({7'd0, !s});
    endtask

    task automatic rd(input logic mack, input logic [7:0] exp_v, input int req);
        logic [7:0] v;
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        bit_out(!mack);
        exp_q.push_back('{req, exp_v});
        obs_q.push_back(v);
    endtask

    task automatic byte_write(input logic [6:0] ofs, input logic [7:0] v, input int req);
        bus_start(); wr(8'hD2, 1, req); wr({1'b1, ofs}, 1, req); wr(v, 1, req); bus_stop();
    endtask

    task automatic byte_read(input logic [6:0] ofs, input logic [7:0] exp_v, input int req);
        bus_start(); wr(8'hD2, 1, req); wr({1'b1, ofs}, 1, req);
        bus_start(); wr(8'hD3, 1, req); rd(0, exp_v, req); bus_stop();
    endtask

    initial begin
        wq(5);
        rst = 1'b0;
        wq(5);
        // R6 R8 R10: reset state at the ports
        check("out1_en reset", 6, {7'd0, out1_en}, 8'd1);        // R6
        check("out2_en reset", 6, {7'd0, out2_en}, 8'd1);        // R6
        check("spread_en reset", 8, {7'd0, spread_en}, 8'd1);    // R8
        check("center_spread reset", 8, {7'd0, center_spread}, 8'd0); // R8
        check("sda_oe reset", 10, {7'd0, sda_oe}, 8'd0);         // R10

        // R5 R6 R12: default block read, count 0x0F then offsets 0..14, then 0xFF
        bus_start(); wr(8'hD2, 1, 5); wr(8'h00, 1, 5);
        bus_start(); wr(8'hD3, 1, 5);
        rd(1, 8'h0F, 5);                                          // R5 count byte
        for (int i = 0; i < 15; i++) begin
            logic [7:0] e;
            case (i)
                4: e = 8'h62;  7: e = 8'h25;  8: e = 8'hA0;  12: e = 8'h0F;
                default: e = 8'h00;                                // R6 R12
            endcase
            rd(1, e, 6);
        end
        rd(0, 8'hFF, 5);                                          // R5 past count
        bus_stop();

        // R1: foreign address ignored, later bytes not acknowledged
        bus_start(); wr(8'hA4, 0, 1); wr(8'h84, 0, 1); wr(8'h00, 0, 1); bus_stop();
        bus_start(); wr(8'hD5, 0, 1); bus_stop();
        byte_read(7'd4, 8'h62, 1);                                // R1 no change

        // R2 R8: single write, second data byte refused
        bus_start(); wr(8'hD2, 1, 2); wr(8'h84, 1, 2); wr(8'h00, 1, 2); wr(8'h11, 0, 2); bus_stop();
        check("out1_en cleared", 8, {7'd0, out1_en}, 8'd0);       // R8
        check("out2_en cleared", 8, {7'd0, out2_en}, 8'd0);       // R8
        check("spread_en cleared", 8, {7'd0, spread_en}, 8'd0);   // R8
        byte_read(7'd4, 8'h00, 4);                                // R4
        byte_read(7'd5, 8'h00, 2);                                // R2 second byte not stored
        byte_write(7'd4, 8'h40, 8);
        check("out1_en only", 8, {out1_en, out2_en, spread_en, 5'd0}, 8'h80); // R8
        byte_write(7'd1, 8'h40, 8);
        check("center_spread set", 8, {7'd0, center_spread}, 8'd1); // R8

        // R7: identification fields
        byte_write(7'd7, 8'hFF, 7);
        byte_read(7'd7, 8'h25, 7);                                // R7
        byte_write(7'd8, 8'hFF, 7);
        byte_read(7'd8, 8'hAF, 7);                                // R7

        // R3: block write limited by count
        bus_start(); wr(8'hD2, 1, 3); wr(8'h00, 1, 3); wr(8'h03, 1, 3);
        wr(8'h11, 1, 3); wr(8'h22, 1, 3); wr(8'h33, 1, 3); wr(8'h44, 0, 3); bus_stop();
        byte_read(7'd0, 8'h11, 3);                                // R3
        byte_read(7'd2, 8'h33, 3);                                // R3
        byte_read(7'd3, 8'h00, 3);                                // R3 extra byte dropped
        check("center_spread follows block write", 8, {7'd0, center_spread}, 8'd0); // R8

        // R5: programmed count shortens block read
        byte_write(7'd12, 8'h02, 5);
        bus_start(); wr(8'hD2, 1, 5); wr(8'h00, 1, 5);
        bus_start(); wr(8'hD3, 1, 5);
        rd(1, 8'h02, 5); rd(1, 8'h11, 5); rd(1, 8'h22, 5); rd(0, 8'hFF, 5); // R5
        bus_stop();

        // R9: stop inside a byte, then repeated start inside a byte
        bus_start(); wr(8'hD2, 1, 9); wr(8'h84, 1, 9);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_stop();
        check("sda_oe after abort", 9, {7'd0, sda_oe}, 8'd0);     // R9
        byte_read(7'd4, 8'h40, 9);                                // R9 unchanged
        bus_start(); wr(8'hD2, 1, 9); wr(8'h85, 1, 9);
        for (int i = 0; i < 3; i++) bit_out(1'b0);
        bus_start(); wr(8'hD2, 1, 9); wr(8'h85, 1, 9); wr(8'h5A, 1, 9); bus_stop();
        byte_read(7'd5, 8'h5A, 9);                                // R9

        // R12: offset beyond the bank
        byte_write(7'd20, 8'h77, 12);
        byte_read(7'd20, 8'h00, 12);                              // R12
        byte_read(7'd7, 8'h25, 12);                               // R12 no aliasing

        // R11: master ACK gets another byte, NACK releases
        bus_start(); wr(8'hD2, 1, 11); wr(8'h85, 1, 11);
        bus_start(); wr(8'hD3, 1, 11);
        rd(1, 8'h5A, 11); rd(0, 8'hFF, 11);                       // R11
        wq(2);
        check("sda_oe after master NACK", 11, {7'd0, sda_oe}, 8'd0); // R11
        bus_stop();

        wq(20);
        check("pull-down while clock high count", 10, bad_pull[7:0], 8'd0); // R10
        while (obs_q.size() != 0) wq(1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule